// File: doc/BRIEF.md
# I2C Downstream Channel Selector

This block is an I2C target that owns the selection register of an eight-way downstream bus switch. It watches SCL and SDA, recognises START and STOP conditions, and answers to one 7-bit address. The upper four address bits are fixed at binary 1110, and the lower three come from strap pins. A master writes one byte to choose which downstream channels are connected. It can read the same byte back to learn the current selection.

Any written byte is held as a pending selection. The eight channel-enable outputs take the new value only when a STOP closes the transaction. By then every line is back at its idle high level, so joining a channel cannot create a false bus condition. The analog pass gates are driven from these enables outside the block. The block drives SDA only as an open-drain pull-down enable. An asynchronous active-low reset, which also stands in for power-on reset, clears the register and returns the bus engine to idle.

Top module: `i2c_chan_switch`

## Requirements
- R1: While reset is low, and after it is released, the control register reads as 0x00, all channel enables are 0, and SDA is not pulled low.
- R2: The block answers only to the address {1110, A2, A1, A0}, with A2..A0 taken from `addr_pins_i[2:0]`. It acknowledges by pulling SDA low during the ninth SCL pulse. The eighth bit after START selects the operation: 1 is a read and 0 is a write.
- R3: After an address that does not match, the block gives no acknowledge, including for any later bytes. It does not change the register or the pending selection, and it stays idle until the next START.
- R4: In a write, each data byte after the address is stored in the control register. When several bytes arrive in one transaction, the last one is kept.
- R5: Channel enable n follows register bit n, for n = 0..7, and any combination may be set. A new value reaches the enables only at a STOP. It does not appear at the data-byte acknowledge or at a repeated START.
- R6: A read returns the control register most significant bit first, including a value that has been written but not yet committed. The byte is sent again for each byte the master acknowledges.
- R7: When the master does not acknowledge a read byte, the block releases SDA and ignores further clocks until a STOP or a repeated START.
- R8: Every data byte of a matched write is acknowledged with SDA low during the ninth SCL pulse.
- R9: A reset asserted during a transaction aborts it and clears the register and the enables. The next transaction then works normally.
- R10: The SDA pull-down enable changes only while the synchronised SCL is low.
- R11: SCL and SDA pass through two synchronising flip-flops. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than eight times SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| addr_pins_i | input | 3 | Strap pins A2..A0 forming the low address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| chan_en_o | output | 8 | Channel enables, bit n for channel n |

## Verification
Five properties are checked on every cycle:
- SDA only moves while SCL is low.
- Every register write is followed by an acknowledge drive.
- An acknowledge is only given for the block's own address.
- A non-matching transaction stays silent until the next START.
- The enables only move right after a STOP.

The bench scenarios show the parts no single-cycle property can:
- The register contents and the read-back bit order.
- Last-byte-wins across multi-byte writes.
- Enables that are held across a repeated START.
- Recovery after a read NACK.
- Recovery after a reset in mid-transaction.

// File: rtl/i2cmux_pkg.sv
// Shared types for the I2C channel selector.
package i2cmux_pkg;

    // Bus engine states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT
    } tgt_state_t;

    // One-cycle bus events from the line synchroniser.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2cmux_line_sync.sv
// Line synchroniser: brings SCL and SDA into the clock domain through a
// flop chain and derives START, STOP and SCL edge pulses.
// Assumes the bus idles high, so the chain resets to 1 and reset
// release on an idle bus creates no event.
module i2cmux_line_sync
    import i2cmux_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o,
    output logic     scl_s_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    // Synchronising chains, one per line.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Previous synchronised levels for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Event decode: data edges while clock is high mark frame bounds.
    always_comb begin
        evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt_o.scl_rise = scl_s & ~scl_q;
        evt_o.scl_fall = ~scl_s & scl_q;
        evt_o.sda      = sda_s;
    end

    assign scl_s_o = scl_s;

endmodule

// File: rtl/i2cmux_target.sv
// Bus engine: receives the address byte, checks it against the fixed
// prefix and strap pins, acknowledges, and then shifts data in
// (write) or out (read). Issues a one-cycle write strobe at the end of
// each received data byte. Assumes at least a few system clocks per
// SCL phase, so SDA changes land well inside SCL low.
module i2cmux_target
    import i2cmux_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter int          PFX_W  = 4,
    parameter int          PIN_W  = 3,
    parameter logic [PFX_W-1:0] PREFIX = 4'b1110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt_i,
    input  logic              scl_s_i,
    input  logic [PIN_W-1:0]  addr_pins_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o
);

    localparam int ADDR_W = PFX_W + PIN_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    tgt_state_t        state;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              rnw;
    logic              mst_ack;
    logic [ADDR_W-1:0] my_addr;
    logic              byte_done;

    assign my_addr   = {PREFIX, addr_pins_i};
    assign byte_done = evt_i.scl_fall && (bitcnt == FULL);

    // Main bus state machine; START and STOP override every state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rnw     <= 1'b0;
            mst_ack <= 1'b0;
        end else if (evt_i.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
        end else if (evt_i.stop) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (evt_i.scl_rise) begin
                        rx_sh  <= {rx_sh[DATA_W-2:0], evt_i.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        if (rx_sh[DATA_W-1 -: ADDR_W] == my_addr) begin
                            rnw   <= rx_sh[0];
                            state <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt_i.scl_fall) begin
                        bitcnt <= '0;
                        if (rnw) begin
                            tx_sh <= rd_data_i;
                            state <= ST_RD_DATA;
                        end else begin
                            state <= ST_WR_DATA;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (evt_i.scl_rise) begin
                        rx_sh  <= {rx_sh[DATA_W-2:0], evt_i.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        state <= ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (evt_i.scl_fall) begin
                        bitcnt <= '0;
                        state  <= ST_WR_DATA;
                    end
                end
                ST_RD_DATA: begin
                    if (evt_i.scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        state <= ST_RD_ACK;
                    end else if (evt_i.scl_fall && bitcnt != '0) begin
                        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    if (evt_i.scl_rise) begin
                        mst_ack <= ~evt_i.sda;
                    end else if (evt_i.scl_fall) begin
                        if (mst_ack) begin
                            tx_sh  <= rd_data_i;
                            bitcnt <= '0;
                            state  <= ST_RD_DATA;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: begin
                    state <= state;
                end
            endcase
        end
    end

    // Open-drain drive: acknowledge slots and zero bits of read data.
    always_comb begin
        sda_oe_o = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                   ((state == ST_RD_DATA) && !tx_sh[DATA_W-1]);
    end

    // Write strobe at the close of each received data byte.
    always_comb begin
        wr_en_o   = (state == ST_WR_DATA) && byte_done &&
                    !evt_i.start && !evt_i.stop;
        wr_data_o = rx_sh;
    end

    assert_ack_own_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (rx_sh[DATA_W-1 -: ADDR_W] == my_addr));

    assert_wait_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !evt_i.start) |=>
        (!sda_oe_o && (state == ST_WAIT || state == ST_IDLE)));

    assert_wr_then_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> sda_oe_o);

    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s_i);

endmodule

// File: rtl/i2cmux_chan_reg.sv
// Selection register and channel enables. The register takes each
// write strobe at once. The enables copy it only on a commit pulse,
// which is the STOP event, and only when a write is pending.
module i2cmux_chan_reg #(
    parameter int CHANNELS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [CHANNELS-1:0] wr_data_i,
    input  logic                commit_i,
    output logic [CHANNELS-1:0] ctrl_o,
    output logic [CHANNELS-1:0] chan_en_o
);

    logic [CHANNELS-1:0] ctrl_q;
    logic                pending;

    // Register write and pending flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            pending <= 1'b0;
        end else if (wr_en_i) begin
            ctrl_q  <= wr_data_i;
            pending <= 1'b1;
        end else if (commit_i) begin
            pending <= 1'b0;
        end
    end

    // One enable flop per channel, loaded at commit.
    generate
        for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chan_en_o[ch] <= 1'b0;
                end else if (commit_i && pending) begin
                    chan_en_o[ch] <= ctrl_q[ch];
                end
            end
        end
    endgenerate

    assign ctrl_o = ctrl_q;

    assert_enables_move_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_en_o) |-> $past(commit_i));

endmodule

// File: rtl/i2c_chan_switch.sv
// Top level of the I2C channel selector: line synchroniser, bus engine
// and selection register. Assumes the system clock runs at least
// eight times faster than SCL.
module i2c_chan_switch
    import i2cmux_pkg::*;
#(
    parameter int CHANNELS    = 8,
    parameter int PIN_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [PIN_W-1:0]    addr_pins_i,
    output logic                sda_oe_o,
    output logic [CHANNELS-1:0] chan_en_o
);

    localparam int PFX_W = 7 - PIN_W;
    localparam logic [PFX_W-1:0] PREFIX = PFX_W'(4'b1110 >> (PIN_W - 3));

    bus_evt_t            evt;
    logic                scl_s;
    logic                wr_en;
    logic [CHANNELS-1:0] wr_data;
    logic [CHANNELS-1:0] ctrl;

    i2cmux_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .evt_o   (evt),
        .scl_s_o (scl_s)
    );

    i2cmux_target #(
        .DATA_W (CHANNELS),
        .PFX_W  (PFX_W),
        .PIN_W  (PIN_W),
        .PREFIX (PREFIX)
    ) u_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .scl_s_i     (scl_s),
        .addr_pins_i (addr_pins_i),
        .rd_data_i   (ctrl),
        .sda_oe_o    (sda_oe_o),
        .wr_en_o     (wr_en),
        .wr_data_o   (wr_data)
    );

    i2cmux_chan_reg #(
        .CHANNELS (CHANNELS)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .commit_i  (evt.stop),
        .ctrl_o    (ctrl),
        .chan_en_o (chan_en_o)
    );

endmodule

// File: tb/i2c_chan_switch_tb.sv
// Bench for the I2C channel selector: directed corner cases plus
// seeded random transactions checked against a bench-side model.
module i2c_chan_switch_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 6;
    localparam int WDOG       = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       sda_oe;
    logic [7:0] chan_en;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] reg_m  = 8'h00;
    logic [7:0] chan_m = 8'h00;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_chan_switch dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .addr_pins_i (pins),
        .sda_oe_o    (sda_oe),
        .chan_en_o   (chan_en)
    );

    function automatic logic [6:0] own_addr(input logic [2:0] p);
        return {4'b1110, p};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
        wait_q();
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q();
        seen = sda_line;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    // Send a byte; nack is 1 when SDA stayed high in the ninth clock.
    task automatic send_byte(input logic [7:0] b, output logic nack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, nack);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d[], input string req);
        logic nack;
        logic hit;
        hit = (a == own_addr(pins));
        bus_start();
        send_byte({a, 1'b0}, nack);
        check({req, " R2 addr ack"}, nack, !hit);
        foreach (d[i]) begin
            send_byte(d[i], nack);
            check({req, " R8 data ack"}, nack, !hit);
            if (hit) reg_m = d[i];
        end
        check({req, " R5 held before stop"}, chan_en, chan_m);
        bus_stop();
        chan_m = reg_m;
        check({req, " R5 enables after stop"}, chan_en, chan_m);
    endtask

    task automatic do_read(input int n, input string req);
        logic nack;
        logic [7:0] b;
        bus_start();
        send_byte({own_addr(pins), 1'b1}, nack);
        check({req, " R2 read addr ack"}, nack, 0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            check({req, " R6 read data"}, b, reg_m);
        end
        bus_stop();
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic nack;
        logic [7:0] b;
        logic [7:0] dv[];
        void'($urandom(32'd20240930));

        // R1: reset state.
        repeat (5) @(negedge clk);
        check("R1 enables in reset", chan_en, 0);
        check("R1 sda in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 enables after reset", chan_en, 0);
        check("R1 sda after reset", sda_oe, 0);
        do_read(1, "R1 register reads zero");

        // R9 / R5: single write, bits map one to one.
        dv = '{8'h4C};
        do_write(own_addr(pins), dv, "R9 single");

        // R4: several bytes, last wins.
        dv = '{8'h11, 8'h22, 8'h81};
        do_write(own_addr(pins), dv, "R4 multi");

        // R5 / R11 / R6: repeated START keeps enables, read sees pending.
        bus_start();
        send_byte({own_addr(pins), 1'b0}, nack);
        send_byte(8'hF0, nack);
        reg_m = 8'hF0;
        check("R8 ack before restart", nack, 0);
        bus_start();
        check("R5 enables held over restart", chan_en, chan_m);
        send_byte({own_addr(pins), 1'b1}, nack);
        check("R11 restart read addr ack", nack, 0);
        recv_byte(1'b1, b);
        check("R6 pending readback", b, 8'hF0);
        recv_byte(1'b0, b);
        check("R6 second read byte", b, 8'hF0);
        // R7: after NACK further clocks see SDA released.
        send_byte(8'hFF, nack);
        check("R7 released after nack", nack, 1);
        check("R5 still held before stop", chan_en, chan_m);
        bus_stop();
        chan_m = reg_m;
        check("R5 committed at stop", chan_en, 8'hF0);

        // R3: wrong prefix, then an own-address pattern without START.
        bus_start();
        send_byte({7'h50, 1'b0}, nack);
        check("R3 mismatch no ack", nack, 1);
        send_byte({own_addr(pins), 1'b0}, nack);
        check("R3 no ack without start", nack, 1);
        send_byte(8'h00, nack);
        check("R3 data ignored", nack, 1);
        bus_stop();
        check("R3 enables unchanged", chan_en, chan_m);
        // R3: pins differ only.
        dv = '{8'h0F};
        do_write({4'b1110, ~pins}, dv, "R3 pin mismatch");
        do_read(1, "R3 register unchanged");

        // R9: reset in mid-transaction.
        bus_start();
        send_byte({own_addr(pins), 1'b0}, nack);
        sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); scl_m = 1'b0; wait_q();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 enables cleared", chan_en, 0);
        check("R9 sda released", sda_oe, 0);
        sda_m = 1'b1; scl_m = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        reg_m = 8'h00; chan_m = 8'h00;
        repeat (4) @(negedge clk);
        do_read(1, "R9 register cleared");
        dv = '{8'hA5};
        do_write(own_addr(pins), dv, "R9 after reset");

        // Random traffic.
        for (int t = 0; t < 40; t++) begin
            int kind;
            int nb;
            logic [6:0] a;
            pins = 3'($urandom_range(0, 7));
            kind = $urandom_range(0, 3);
            nb   = $urandom_range(1, 3);
            if (kind < 2) begin
                a = ($urandom_range(0, 3) != 0) ? own_addr(pins) : 7'($urandom_range(0, 127));
                dv = new[nb];
                foreach (dv[i]) dv[i] = 8'($urandom_range(0, 255));
                do_write(a, dv, "R4 random write");
            end else begin
                do_read(nb, "R6 random read");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule